// File: doc/BRIEF.md
# Configurable Pixel Format Packer

The packer accepts one pixel per cycle as four 8-bit channels (red, green, blue, alpha) on a valid/ready stream and returns it encoded in one of several memory layouts. It produces a 32-bit pixel word, a per-byte write strobe and a count of the meaningful bytes. A 4-bit format code picks the layout: 16-bit four-channel words with 4 bits per channel, 16-bit 565 words, 24-bit three-channel words, or 32-bit four-channel words. The four-channel and three-channel layouts each come in several channel orders.

The alpha byte can be written as received, written bitwise inverted, or replaced by a constant. Two control bits pick among these: an alpha-keep bit and an alpha-flip bit. A 4-bit lane-enable mask gates each byte strobe.

The format, alpha and lane controls are sampled together with the pixel they apply to. The result appears after one register stage. A stalled output holds its value and blocks new input, so no pixel is lost or duplicated.

Top module: `pix_fmt_packer`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Codes 0, 1, 2 and 3 give 16-bit words with 4 bits per channel, taken from the top nibble of each channel. The channel order from bit 15 down is A,B,G,R (code 0), A,R,G,B (code 1), B,G,R,A (code 2) and R,G,B,A (code 3). Bits 31:16 are 0.
- R3: Code 6 gives {B[7:3], G[7:2], R[7:3]} in bits 15:0, and code 7 gives {R[7:3], G[7:2], B[7:3]}. Bits 31:16 are 0.
- R4: Code 8 gives {B,G,R} in bits 23:0, and code 9 gives {R,G,B}. Bits 31:24 are 0.
- R5: Codes 12, 13, 14 and 15 give 32-bit words. Byte 3 down to byte 0 hold A,B,G,R (code 12), A,R,G,B (code 13), B,G,R,A (code 14) and R,G,B,A (code 15).
- R6: With alpha-keep set, the alpha field carries the input alpha, inverted bitwise when alpha-flip is set.
- R7: With alpha-keep clear, the alpha field is all ones when alpha-flip is set and all zeros otherwise.
- R8: `out_strb[i]` is 1 exactly when lane-enable bit i is set and i is below `out_nbytes`.
- R9: Codes 4, 5, 10 and 11 give `out_fmt_err` = 1, with word, strobe and byte count all 0. Every other code gives `out_fmt_err` = 0.
- R10: `out_nbytes` is 2 for codes 0-3 and 6-7, 3 for codes 8-9, and 4 for codes 12-15.
- R11: A pixel accepted on a cycle with `in_valid` and `in_ready` high appears on the outputs the following cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the outputs hold steady. Pixels leave in order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Packer can take a pixel |
| in_red | input | 8 | Red channel |
| in_green | input | 8 | Green channel |
| in_blue | input | 8 | Blue channel |
| in_alpha | input | 8 | Alpha channel |
| cfg_format | input | 4 | Layout code |
| cfg_alpha_keep | input | 1 | Store alpha instead of a constant |
| cfg_alpha_flip | input | 1 | Invert the stored alpha, or pick the all-ones constant |
| cfg_lane_en | input | 4 | Per-byte strobe enables |
| out_valid | output | 1 | Packed pixel present |
| out_ready | input | 1 | Downstream takes the packed pixel |
| out_word | output | 32 | Packed pixel word |
| out_strb | output | 4 | Byte write strobes |
| out_nbytes | output | 3 | Meaningful byte count |
| out_fmt_err | output | 1 | Unused format code seen |

## Verification
The bench runs every one of the sixteen codes under all four alpha-control combinations. A swapped order table would put a channel in the wrong byte or nibble. A reduction using low bits instead of top bits would differ as soon as the channel values carry distinct high and low nibbles. The unused codes are driven with non-zero pixels and full lane masks, so any strobe or stray data leaking through is caught. Long random runs with a stalling consumer and mixed lane masks expose a stage that overwrites a held pixel, drops one when in_ready is computed wrongly, or sets strobes above the byte count.

// File: rtl/pkp_pkg.sv
package pkp_pkg;
  localparam int CH_W   = 8;
  localparam int N_CH   = 4;
  localparam int WORD_W = CH_W * N_CH;
  localparam int CNT_W  = $clog2(N_CH + 1);
  localparam int CODE_W = 4;
  localparam int NIB_W  = CH_W / 2;
  localparam int RB_W   = 5;
  localparam int G6_W   = 6;
  localparam int N_ORD  = 4;

  typedef logic [CH_W-1:0] chan_t;

  typedef enum logic [2:0] {
    LAY_NONE,
    LAY_NIB,
    LAY_565,
    LAY_TRI,
    LAY_QUAD
  } layout_e;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [N_CH-1:0]   strb;
    logic [CNT_W-1:0]  nbytes;
    logic              err;
  } packed_px_t;
endpackage

// File: rtl/pkp_decode.sv
module pkp_decode
  import pkp_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output layout_e           layout,
  output logic [1:0]        order,
  output logic [CNT_W-1:0]  nbytes
);
  always_comb begin
    unique case (code)
      4'd0, 4'd1, 4'd2, 4'd3:     layout = LAY_NIB;
      4'd6, 4'd7:                 layout = LAY_565;
      4'd8, 4'd9:                 layout = LAY_TRI;
      4'd12, 4'd13, 4'd14, 4'd15: layout = LAY_QUAD;
      default:                    layout = LAY_NONE;
    endcase
  end

  assign order = code[1:0];

  always_comb begin
    unique case (layout)
      LAY_NIB, LAY_565: nbytes = CNT_W'(2);
      LAY_TRI:          nbytes = CNT_W'(3);
      LAY_QUAD:         nbytes = CNT_W'(N_CH);
      default:          nbytes = '0;
    endcase
  end
endmodule

// File: rtl/pkp_alpha.sv
module pkp_alpha
  import pkp_pkg::*;
(
  input  chan_t alpha_in,
  input  logic  keep,
  input  logic  flip,
  output chan_t alpha_out
);
  // keep: pass (optionally inverted); otherwise the flip bit picks the constant
  assign alpha_out = keep ? (alpha_in ^ {CH_W{flip}}) : {CH_W{flip}};
endmodule

// File: rtl/pkp_encode.sv
module pkp_encode
  import pkp_pkg::*;
(
  input  chan_t             red,
  input  chan_t             green,
  input  chan_t             blue,
  input  chan_t             alpha,
  input  layout_e           layout,
  input  logic [1:0]        order,
  output logic [WORD_W-1:0] word
);
  logic [N_CH-1:0][CH_W-1:0] quad_seq [N_ORD];
  logic [N_CH*NIB_W-1:0]     nib_seq  [N_ORD];

  // Four-channel orders, most significant channel first
  for (genvar o = 0; o < N_ORD; o++) begin : g_ord
    if (o == 0) begin : g_abgr
      assign quad_seq[o] = {alpha, blue, green, red};
    end else if (o == 1) begin : g_argb
      assign quad_seq[o] = {alpha, red, green, blue};
    end else if (o == 2) begin : g_bgra
      assign quad_seq[o] = {blue, green, red, alpha};
    end else begin : g_rgba
      assign quad_seq[o] = {red, green, blue, alpha};
    end
    for (genvar c = 0; c < N_CH; c++) begin : g_nib
      assign nib_seq[o][c*NIB_W +: NIB_W] = quad_seq[o][c][CH_W-1 -: NIB_W];
    end
  end

  logic [2:0][CH_W-1:0]       tri_seq;
  logic [2*RB_W+G6_W-1:0]     w565;

  assign tri_seq = order[0] ? {red, green, blue} : {blue, green, red};
  assign w565    = {tri_seq[2][CH_W-1 -: RB_W],
                    tri_seq[1][CH_W-1 -: G6_W],
                    tri_seq[0][CH_W-1 -: RB_W]};

  always_comb begin
    unique case (layout)
      LAY_NIB:  word = WORD_W'(nib_seq[order]);
      LAY_565:  word = WORD_W'(w565);
      LAY_TRI:  word = WORD_W'(tri_seq);
      LAY_QUAD: word = quad_seq[order];
      default:  word = '0;
    endcase
  end
endmodule

// File: rtl/pkp_outreg.sv
module pkp_outreg
  import pkp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  packed_px_t in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output packed_px_t out_data
);
  logic       vld_q;
  packed_px_t data_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
endmodule

// File: rtl/pix_fmt_packer.sv
module pix_fmt_packer
  import pkp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_red,
  input  logic [CH_W-1:0]   in_green,
  input  logic [CH_W-1:0]   in_blue,
  input  logic [CH_W-1:0]   in_alpha,
  input  logic [CODE_W-1:0] cfg_format,
  input  logic              cfg_alpha_keep,
  input  logic              cfg_alpha_flip,
  input  logic [N_CH-1:0]   cfg_lane_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [N_CH-1:0]   out_strb,
  output logic [CNT_W-1:0]  out_nbytes,
  output logic              out_fmt_err
);
  layout_e           layout;
  logic [1:0]        order;
  logic [CNT_W-1:0]  nbytes;
  chan_t             alpha_eff;
  logic [WORD_W-1:0] word;
  logic [N_CH-1:0]   strb;
  packed_px_t        stage_in;
  packed_px_t        stage_out;

  pkp_decode u_dec (
    .code   (cfg_format),
    .layout (layout),
    .order  (order),
    .nbytes (nbytes)
  );

  pkp_alpha u_alpha (
    .alpha_in  (in_alpha),
    .keep      (cfg_alpha_keep),
    .flip      (cfg_alpha_flip),
    .alpha_out (alpha_eff)
  );

  pkp_encode u_enc (
    .red    (in_red),
    .green  (in_green),
    .blue   (in_blue),
    .alpha  (alpha_eff),
    .layout (layout),
    .order  (order),
    .word   (word)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_lane
    assign strb[i] = cfg_lane_en[i] && (CNT_W'(i) < nbytes);
  end

  assign stage_in.word   = word;
  assign stage_in.strb   = strb;
  assign stage_in.nbytes = nbytes;
  assign stage_in.err    = (layout == LAY_NONE);

  pkp_outreg u_reg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (stage_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_out)
  );

  assign out_word    = stage_out.word;
  assign out_strb    = stage_out.strb;
  assign out_nbytes  = stage_out.nbytes;
  assign out_fmt_err = stage_out.err;
endmodule

// File: rtl/pkp_checker.sv
module pkp_checker
  import pkp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic [N_CH-1:0]   out_strb,
  input logic [CNT_W-1:0]  out_nbytes,
  input logic              out_fmt_err
);
  logic [N_CH-1:0] lane_ok;
  for (genvar i = 0; i < N_CH; i++) begin : g_ok
    assign lane_ok[i] = (CNT_W'(i) < out_nbytes);
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_strb)
                                    && $stable(out_nbytes) && $stable(out_fmt_err)));

  assert_ready_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_bad_code_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fmt_err) |-> (out_strb == '0 && out_nbytes == '0 && out_word == '0));

  assert_count_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fmt_err) |-> (out_nbytes >= CNT_W'(2) && out_nbytes <= CNT_W'(N_CH)));

  assert_lane_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_strb & ~lane_ok) == '0));

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nbytes == CNT_W'(2)) |-> (out_word[WORD_W-1:16] == '0));
endmodule

bind pix_fmt_packer pkp_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_word    (out_word),
  .out_strb    (out_strb),
  .out_nbytes  (out_nbytes),
  .out_fmt_err (out_fmt_err)
);

// File: tb/pix_fmt_packer_tb_top.sv
module pix_fmt_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0, in_ready;
  logic [7:0] in_red = 0, in_green = 0, in_blue = 0, in_alpha = 0;
  logic [3:0] cfg_format = 0;
  logic cfg_alpha_keep = 0, cfg_alpha_flip = 0;
  logic [3:0] cfg_lane_en = 0;
  logic out_valid, out_ready = 0;
  logic [31:0] out_word;
  logic [3:0] out_strb;
  logic [2:0] out_nbytes;
  logic out_fmt_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_fmt_packer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_red(in_red), .in_green(in_green), .in_blue(in_blue), .in_alpha(in_alpha),
    .cfg_format(cfg_format), .cfg_alpha_keep(cfg_alpha_keep),
    .cfg_alpha_flip(cfg_alpha_flip), .cfg_lane_en(cfg_lane_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_strb(out_strb), .out_nbytes(out_nbytes), .out_fmt_err(out_fmt_err)
  );

  typedef struct {
    logic [31:0] w;
    logic [3:0]  s;
    logic [2:0]  n;
    logic        e;
    logic [3:0]  code;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic string word_tag(input logic [3:0] code);
    if (code <= 3)                return "R2 R6 R7";
    if (code == 6 || code == 7)   return "R3";
    if (code == 8 || code == 9)   return "R4";
    if (code >= 12)               return "R5 R6 R7";
    return "R9";
  endfunction

  function automatic exp_t model(input logic [3:0] code, input logic [7:0] r, g, b, a,
                                 input logic keep, flip, input logic [3:0] lanes);
    exp_t x;
    logic [7:0] al;
    int n;
    al = keep ? (flip ? ~a : a) : (flip ? 8'hFF : 8'h00);
    case (code)
      0:  x.w = {16'h0, al[7:4], b[7:4], g[7:4], r[7:4]};
      1:  x.w = {16'h0, al[7:4], r[7:4], g[7:4], b[7:4]};
      2:  x.w = {16'h0, b[7:4], g[7:4], r[7:4], al[7:4]};
      3:  x.w = {16'h0, r[7:4], g[7:4], b[7:4], al[7:4]};
      6:  x.w = {16'h0, b[7:3], g[7:2], r[7:3]};
      7:  x.w = {16'h0, r[7:3], g[7:2], b[7:3]};
      8:  x.w = {8'h0, b, g, r};
      9:  x.w = {8'h0, r, g, b};
      12: x.w = {al, b, g, r};
      13: x.w = {al, r, g, b};
      14: x.w = {b, g, r, al};
      15: x.w = {r, g, b, al};
      default: x.w = 32'h0;
    endcase
    if (code <= 3 || code == 6 || code == 7) n = 2;
    else if (code == 8 || code == 9)         n = 3;
    else if (code >= 12)                     n = 4;
    else                                     n = 0;
    x.n = 3'(n);
    x.e = (n == 0);
    x.s = 4'h0;
    for (int i = 0; i < 4; i++) x.s[i] = lanes[i] && (i < n);
    x.code = code;
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare the outputs with the model, drive the next inputs, update the model
  task automatic step(input logic v, input logic [3:0] code, input logic [7:0] r, g, b, a,
                      input logic keep, flip, input logic [3:0] lanes, input logic ordy);
    exp_t x;
    bit exp_rdy;
    @(negedge clk);
    chk(out_valid == (q.size() > 0), "R11 valid", 32'(out_valid), 32'(q.size() > 0));
    if (q.size() > 0 && out_valid) begin
      chk(out_word == q[0].w, word_tag(q[0].code), out_word, q[0].w);
      chk(out_strb == q[0].s, "R8 strobe", 32'(out_strb), 32'(q[0].s));
      chk(out_nbytes == q[0].n, "R10 count", 32'(out_nbytes), 32'(q[0].n));
      chk(out_fmt_err == q[0].e, "R9 error flag", 32'(out_fmt_err), 32'(q[0].e));
    end
    in_valid = v; cfg_format = code; in_red = r; in_green = g; in_blue = b; in_alpha = a;
    cfg_alpha_keep = keep; cfg_alpha_flip = flip; cfg_lane_en = lanes; out_ready = ordy;
    #1;
    exp_rdy = (q.size() == 0) || ordy;
    chk(in_ready == exp_rdy, "R11 ready", 32'(in_ready), 32'(exp_rdy));
    if (q.size() > 0 && ordy) void'(q.pop_front());
    if (v && exp_rdy) begin
      x = model(code, r, g, b, a, keep, flip, lanes);
      q.push_back(x);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid in reset", 32'(out_valid), 0);
    end
    @(negedge clk);
    rst = 0;
    #1;
    chk(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 1);

    // Every code with every alpha control, two distinct pixels (R2-R10)
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 4; m++) begin
        step(1, 4'(c), 8'h9C, 8'h5A, 8'h3E, 8'hC7, m[1], m[0], 4'hF, 1);
        step(1, 4'(c), 8'h1F, 8'hE2, 8'hA5, 8'h38, m[1], m[0], 4'hF, 1);
      end
    end
    // Lane masks against each width (R8)
    for (int l = 0; l < 16; l++) begin
      step(1, 4'd13, 8'h11, 8'h22, 8'h33, 8'h44, 1, 0, 4'(l), 1);
      step(1, 4'd9,  8'h55, 8'h66, 8'h77, 8'h88, 1, 0, 4'(l), 1);
      step(1, 4'd2,  8'hAB, 8'hCD, 8'hEF, 8'h12, 1, 1, 4'(l), 1);
      step(1, 4'd5,  8'hFF, 8'hFF, 8'hFF, 8'hFF, 1, 1, 4'(l), 1);
    end
    // Stall with a held pixel while new input is offered (R11)
    step(1, 4'd15, 8'h01, 8'h02, 8'h03, 8'h04, 1, 0, 4'hF, 0);
    step(1, 4'd12, 8'hF1, 8'hF2, 8'hF3, 8'hF4, 1, 0, 4'hF, 0);
    step(1, 4'd12, 8'hF1, 8'hF2, 8'hF3, 8'hF4, 1, 0, 4'hF, 0);
    step(1, 4'd12, 8'hF1, 8'hF2, 8'hF3, 8'hF4, 1, 0, 4'hF, 1);
    step(0, 4'd0, 0, 0, 0, 0, 0, 0, 4'h0, 1);
    // Random traffic with back-pressure (R11)
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 4) != 0, 4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
           8'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), ($urandom % 3) != 0);
    end
    for (int k = 0; k < 3; k++) step(0, 4'd0, 0, 0, 0, 0, 0, 0, 4'h0, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule